// File: doc/BRIEF.md
# DMA Channel Error Logger

This block collects and records the error conditions of one DMA channel. Each time the channel fetches a descriptor, the block checks the next-descriptor, source and destination addresses. It also takes single-cycle error strobes from the rest of the engine. Every detected error sets a sticky status bit. Software reads these bits and clears them by writing ones.

A per-bit mask decides which logged errors drive the channel interrupt. Masking only suppresses the interrupt; the error is still logged. When a source-address, destination-address or descriptor error is pending and the channel reports that it has halted, the block latches the address of the failing descriptor. That address is held for software until the related status bits are cleared.

Access uses a small register port: a 2-bit select, a write strobe, write data and combinational read data.

Top module: `dma_chan_err_log`

## Requirements
- R1: After reset, status, mask and failed-descriptor address all read 0, and `irq_o` is low.
- R2: On a cycle with `desc_vld_i` high, a source address with any bit at or above bit 40 set sets status bit 0. A destination address with such a bit set sets status bit 1. Neither field is checked for alignment.
- R3: On a cycle with `desc_vld_i` high, a next-descriptor address with any bit at or above bit 40 set sets status bit 2. So does one whose low 6 bits are not zero. Address fields are ignored while `desc_vld_i` is low.
- R4: A pulse on `desc_fail_i` sets status bit 3.
- R5: A pulse on `eng_err_i[k]` sets status bit 4+k.
- R6: A set mask bit leaves the logging of its error unchanged but keeps that error from raising `irq_o`. Clearing the mask bit while the status bit is set raises `irq_o`.
- R7: `irq_o` is high whenever any status bit is set whose mask bit is clear, and it stays high until software clears those status bits or masks them.
- R8: Status bits are sticky. A write with select 0 clears each status bit written as 1 and leaves the bits written as 0 unchanged.
- R9: When an error event and a write-one-to-clear hit the same status bit in one cycle, the bit ends up set.
- R10: A write with select 1 stores write-data bits 11:0 as the mask. Bits 31:12 of the mask read as 0.
- R11: `halt_i` captures the failing descriptor address once bit 0, 1 or 3 has been logged. For a bit 0 or bit 1 error, that address is the `desc_addr_i` of the fetch that failed. For a bit 3 error, it is the address of the most recently fetched descriptor. The address reads as bits 31:0 with select 2, and as bits 39:32 in read bits 7:0 with select 3.
- R12: A captured address is not overwritten by later errors or halts until status bits 0, 1 and 3 are all clear. After that, a new error followed by a halt captures again.
- R13: A halt with no pending bit 0, 1 or 3 error leaves the captured address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_vld_i | input | 1 | Descriptor fields below are valid this cycle |
| desc_addr_i | input | 40 | Address of the descriptor being fetched |
| nxt_addr_i | input | 64 | Fetched next-descriptor address |
| src_addr_i | input | 64 | Fetched source address |
| dst_addr_i | input | 64 | Fetched destination address |
| desc_fail_i | input | 1 | Post-transfer descriptor failure strobe |
| eng_err_i | input | 8 | Other engine error strobes |
| halt_i | input | 1 | Channel has entered the halted state |
| reg_sel_i | input | 2 | Register select: 0 status, 1 mask, 2 address low, 3 address high |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected register |
| irq_o | output | 1 | Channel error interrupt |

## Verification
A hardware error event and a software write-one-to-clear can hit the same status bit in the same cycle. The bench provokes this by first logging an engine error. It then drives the same error strobe in the very cycle it writes a 1 to that bit's position. The bit must still read set afterwards. The bench then repeats the pattern with different bits: the clear succeeds on the written bit while the new event sets its own bit, and the status read-back judges both cases.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;
  typedef enum logic [1:0] {
    SEL_STAT    = 2'd0,
    SEL_MASK    = 2'd1,
    SEL_FAIL_LO = 2'd2,
    SEL_FAIL_HI = 2'd3
  } reg_sel_e;

  localparam int unsigned BIT_SRC  = 0;
  localparam int unsigned BIT_DST  = 1;
  localparam int unsigned BIT_NXT  = 2;
  localparam int unsigned BIT_DESC = 3;
  localparam int unsigned BIT_EXT0 = 4;

  localparam int unsigned NUM_FLD = 3;
  localparam int unsigned FLD_SRC = 0;
  localparam int unsigned FLD_DST = 1;
  localparam int unsigned FLD_NXT = 2;
endpackage

// File: rtl/dma_err_addr_chk.sv
module dma_err_addr_chk #(
  parameter int unsigned FLD_W     = 64,
  parameter int unsigned LEGAL_W   = 40,
  parameter int unsigned ALIGN_LG2 = 6,
  parameter bit          CHK_ALIGN = 1'b0
) (
  input  logic             vld_i,
  input  logic [FLD_W-1:0] addr_i,
  output logic             err_o
);
  logic too_wide;
  logic misal;

  assign too_wide = |addr_i[FLD_W-1:LEGAL_W];

  generate
    if (CHK_ALIGN) begin : g_align
      assign misal = |addr_i[ALIGN_LG2-1:0];
    end else begin : g_noalign
      assign misal = 1'b0;
    end
  endgenerate

  logic unused_mid;
  assign unused_mid = ^addr_i[LEGAL_W-1:0];

  assign err_o = vld_i & (too_wide | misal);
endmodule

// File: rtl/dma_err_stat.sv
module dma_err_stat #(
  parameter int unsigned N = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    // set has priority so a colliding event is never lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q[k] <= 1'b0;
      else if (set_i[k])  q[k] <= 1'b1;
      else if (clr_i[k])  q[k] <= 1'b0;
    end

    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> q[k]);

    assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[k] && !clr_i[k]) |=> $stable(q[k]));
  end

  assign stat_o = q;
endmodule

// File: rtl/dma_err_capt.sv
module dma_err_capt #(
  parameter int unsigned ADDR_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              desc_vld_i,
  input  logic [ADDR_W-1:0] desc_addr_i,
  input  logic              fld_hit_i,
  input  logic              desc_fail_i,
  input  logic              halt_i,
  input  logic [2:0]        rel_stat_i,
  output logic [ADDR_W-1:0] fail_addr_o
);
  logic [ADDR_W-1:0] cur_q, pend_q, fail_q;
  logic              pend_vld_q, cap_vld_q;
  logic              release_w;

  // related bits all clear and nothing arriving this cycle
  assign release_w = (rel_stat_i == 3'b000) && !fld_hit_i && !desc_fail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q      <= '0;
      pend_q     <= '0;
      fail_q     <= '0;
      pend_vld_q <= 1'b0;
      cap_vld_q  <= 1'b0;
    end else begin
      if (desc_vld_i) cur_q <= desc_addr_i;
      if (release_w) begin
        pend_vld_q <= 1'b0;
        cap_vld_q  <= 1'b0;
      end else begin
        if (!pend_vld_q && fld_hit_i) begin
          pend_q     <= desc_addr_i;
          pend_vld_q <= 1'b1;
        end else if (!pend_vld_q && desc_fail_i) begin
          pend_q     <= cur_q;
          pend_vld_q <= 1'b1;
        end
        if (halt_i && pend_vld_q && !cap_vld_q) begin
          fail_q    <= pend_q;
          cap_vld_q <= 1'b1;
        end
      end
    end
  end

  assign fail_addr_o = fail_q;

  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_vld_q && rel_stat_i != 3'b000) |=> $stable(fail_q));

  assert_no_capt_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !pend_vld_q) |=> $stable(fail_q));
endmodule

// File: rtl/dma_chan_err_log.sv
module dma_chan_err_log
  import dma_err_pkg::*;
#(
  parameter int unsigned FLD_W     = 64,
  parameter int unsigned ADDR_W    = 40,
  parameter int unsigned ALIGN_LG2 = 6,
  parameter int unsigned NUM_EXT   = 8,
  parameter int unsigned REG_W     = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               desc_vld_i,
  input  logic [ADDR_W-1:0]  desc_addr_i,
  input  logic [FLD_W-1:0]   nxt_addr_i,
  input  logic [FLD_W-1:0]   src_addr_i,
  input  logic [FLD_W-1:0]   dst_addr_i,
  input  logic               desc_fail_i,
  input  logic [NUM_EXT-1:0] eng_err_i,
  input  logic               halt_i,
  input  logic [1:0]         reg_sel_i,
  input  logic               reg_we_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               irq_o
);
  localparam int unsigned NUM_ERR = BIT_EXT0 + NUM_EXT;
  localparam int unsigned HI_W    = ADDR_W - REG_W;

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel_i);

  logic [FLD_W-1:0]   fld [NUM_FLD];
  logic [NUM_FLD-1:0] chk_err;

  assign fld[FLD_SRC] = src_addr_i;
  assign fld[FLD_DST] = dst_addr_i;
  assign fld[FLD_NXT] = nxt_addr_i;

  for (genvar f = 0; f < NUM_FLD; f++) begin : g_chk
    dma_err_addr_chk #(
      .FLD_W    (FLD_W),
      .LEGAL_W  (ADDR_W),
      .ALIGN_LG2(ALIGN_LG2),
      .CHK_ALIGN(f == FLD_NXT)
    ) u_chk (
      .vld_i (desc_vld_i),
      .addr_i(fld[f]),
      .err_o (chk_err[f])
    );
  end

  logic [NUM_ERR-1:0] set_vec, clr_vec, stat;
  logic [NUM_ERR-1:0] mask_q;

  always_comb begin
    set_vec                     = '0;
    set_vec[BIT_SRC]            = chk_err[FLD_SRC];
    set_vec[BIT_DST]            = chk_err[FLD_DST];
    set_vec[BIT_NXT]            = chk_err[FLD_NXT];
    set_vec[BIT_DESC]           = desc_fail_i;
    set_vec[BIT_EXT0 +: NUM_EXT] = eng_err_i;
  end

  assign clr_vec = (reg_we_i && sel == SEL_STAT) ? reg_wdata_i[NUM_ERR-1:0] : '0;

  dma_err_stat #(.N(NUM_ERR)) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .stat_o(stat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         mask_q <= '0;
    else if (reg_we_i && sel == SEL_MASK) mask_q <= reg_wdata_i[NUM_ERR-1:0];
  end

  logic unused_wd;
  assign unused_wd = ^reg_wdata_i[REG_W-1:NUM_ERR];

  logic [ADDR_W-1:0] fail_addr;

  dma_err_capt #(.ADDR_W(ADDR_W)) u_capt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .desc_vld_i (desc_vld_i),
    .desc_addr_i(desc_addr_i),
    .fld_hit_i  (chk_err[FLD_SRC] | chk_err[FLD_DST]),
    .desc_fail_i(desc_fail_i),
    .halt_i     (halt_i),
    .rel_stat_i ({stat[BIT_DESC], stat[BIT_DST], stat[BIT_SRC]}),
    .fail_addr_o(fail_addr)
  );

  assign irq_o = |(stat & ~mask_q);

  always_comb begin
    unique case (sel)
      SEL_STAT:    reg_rdata_o = REG_W'(stat);
      SEL_MASK:    reg_rdata_o = REG_W'(mask_q);
      SEL_FAIL_LO: reg_rdata_o = fail_addr[REG_W-1:0];
      default:     reg_rdata_o = REG_W'(fail_addr[ADDR_W-1:ADDR_W-HI_W]);
    endcase
  end

  assert_mask_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o);

  assert_irq_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !reg_we_i) |=> irq_o);

  assert_nxt_align_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_vld_i && |nxt_addr_i[ALIGN_LG2-1:0]) |=> stat[BIT_NXT]);
endmodule

// File: tb/dma_chan_err_log_tb_top.sv
module dma_chan_err_log_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_vld = 1'b0;
  logic [39:0] desc_addr = '0;
  logic [63:0] nxt_addr = '0, src_addr = '0, dst_addr = '0;
  logic        desc_fail = 1'b0;
  logic [7:0]  eng_err = '0;
  logic        halt = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_chan_err_log dut_i (
    .clk_i(clk), .rst_ni(rst_n), .desc_vld_i(desc_vld), .desc_addr_i(desc_addr),
    .nxt_addr_i(nxt_addr), .src_addr_i(src_addr), .dst_addr_i(dst_addr),
    .desc_fail_i(desc_fail), .eng_err_i(eng_err), .halt_i(halt),
    .reg_sel_i(reg_sel), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  // scoreboard queues
  bit          kind_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      bit k; logic [31:0] e; string t; logic [31:0] act;
      k = kind_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      act = k ? {31'd0, irq} : reg_rdata;
      n_chk++;
      if (act !== e) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", t, act, e);
      end
    end
  end

  task automatic chk_rd(input logic [1:0] sel, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    reg_sel = sel;
    kind_q.push_back(1'b0); exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); #1;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(posedge clk); #1;
    kind_q.push_back(1'b1); exp_q.push_back({31'd0, e}); tag_q.push_back(t);
    @(negedge clk); #1;
  endtask

  task automatic cyc(input logic [7:0] eng, input logic df, input logic hl,
                     input logic we, input logic [1:0] sel, input logic [31:0] wd);
    @(posedge clk); #1;
    eng_err = eng; desc_fail = df; halt = hl; reg_we = we; reg_sel = sel; reg_wdata = wd;
    @(posedge clk); #1;
    eng_err = '0; desc_fail = 1'b0; halt = 1'b0; reg_we = 1'b0;
  endtask

  task automatic fetch(input logic [39:0] da, input logic [63:0] nx,
                       input logic [63:0] sa, input logic [63:0] dd);
    @(posedge clk); #1;
    desc_vld = 1'b1; desc_addr = da; nxt_addr = nx; src_addr = sa; dst_addr = dd;
    @(posedge clk); #1;
    desc_vld = 1'b0; nxt_addr = '0; src_addr = '0; dst_addr = '0;
  endtask

  task automatic w1c(input logic [31:0] v);
    cyc(8'h00, 1'b0, 1'b0, 1'b1, 2'd0, v);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk_rd(2'd0, 32'h0, "R1 status");
    chk_rd(2'd1, 32'h0, "R1 mask");
    chk_rd(2'd2, 32'h0, "R1 fail lo");
    chk_rd(2'd3, 32'h0, "R1 fail hi");
    chk_irq(1'b0, "R1 irq");

    // legal fetch; misaligned source is not an error (R2), aligned next ok (R3)
    fetch(40'h12_3456_7800, 64'h40, 64'h1003, 64'h2000);
    chk_rd(2'd0, 32'h0, "R2 legal fetch");
    // address fields without desc_vld are ignored (R3)
    @(posedge clk); #1; nxt_addr = 64'h21; src_addr = 64'h1 << 41;
    @(posedge clk); #1; nxt_addr = '0; src_addr = '0;
    chk_rd(2'd0, 32'h0, "R3 no valid strobe");

    // source width error, then halt capture
    fetch(40'hAB_CDEF_0040, 64'h80, 64'h1 << 40, 64'h0);
    chk_rd(2'd0, 32'h1, "R2 src wide");
    chk_irq(1'b1, "R7 irq on error");
    cyc(8'h00, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0);
    chk_rd(2'd2, 32'hCDEF_0040, "R11 fail lo");
    chk_rd(2'd3, 32'h0000_00AB, "R11 fail hi");

    // second error and halt must not overwrite
    fetch(40'h11_0000_0080, 64'h0, 64'h0, 64'h1 << 50);
    chk_rd(2'd0, 32'h3, "R2 dst wide");
    cyc(8'h00, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0);
    chk_rd(2'd2, 32'hCDEF_0040, "R12 hold lo");

    // write one to clear
    w1c(32'h1);
    chk_rd(2'd0, 32'h2, "R8 w1c bit0");
    w1c(32'h0);
    chk_rd(2'd0, 32'h2, "R8 zero write keeps");
    chk_irq(1'b1, "R7 irq holds");
    w1c(32'h2);
    chk_rd(2'd0, 32'h0, "R8 w1c bit1");
    chk_irq(1'b0, "R7 irq drops");

    // descriptor failure uses last fetched address; capture re-armed
    cyc(8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0);
    chk_rd(2'd0, 32'h8, "R4 desc fail");
    cyc(8'h00, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0);
    chk_rd(2'd2, 32'h0000_0080, "R12 recapture lo");
    chk_rd(2'd3, 32'h0000_0011, "R11 recapture hi");
    w1c(32'h8);

    // halt with nothing pending
    cyc(8'h00, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0);
    chk_rd(2'd2, 32'h0000_0080, "R13 no capture");

    // next-descriptor checks
    fetch(40'h0, 64'h1 << 40, 64'h0, 64'h0);
    chk_rd(2'd0, 32'h4, "R3 nxt wide");
    w1c(32'h4);
    fetch(40'h0, 64'h20, 64'h0, 64'h0);
    chk_rd(2'd0, 32'h4, "R3 nxt misaligned");
    w1c(32'h4);

    // engine strobes
    cyc(8'h81, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
    chk_rd(2'd0, 32'h810, "R5 engine bits");
    w1c(32'hFFFF_FFFF);
    chk_rd(2'd0, 32'h0, "R8 clear all");

    // mask behaviour
    cyc(8'h00, 1'b0, 1'b0, 1'b1, 2'd1, 32'hFFFF_FFFF);
    chk_rd(2'd1, 32'h0000_0FFF, "R10 mask reserved");
    cyc(8'h04, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
    chk_rd(2'd0, 32'h40, "R6 masked still logged");
    chk_irq(1'b0, "R6 masked no irq");
    cyc(8'h00, 1'b0, 1'b0, 1'b1, 2'd1, 32'h0);
    chk_irq(1'b1, "R6 unmask raises irq");
    w1c(32'h40);
    chk_irq(1'b0, "R7 cleared");

    // set versus clear collision
    cyc(8'h01, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
    chk_rd(2'd0, 32'h10, "R5 bit4");
    cyc(8'h01, 1'b0, 1'b0, 1'b1, 2'd0, 32'h10);
    chk_rd(2'd0, 32'h10, "R9 set wins");
    cyc(8'h02, 1'b0, 1'b0, 1'b1, 2'd0, 32'h10);
    chk_rd(2'd0, 32'h20, "R9 clear other bit");

    repeat (2) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule